// File: doc/BRIEF.md
# Discovery Event Latch Register

This block keeps the event byte that a four-channel power-sourcing controller reports after port discovery. Each channel engine sends a one-cycle pulse whenever a detection cycle or a classification cycle ends, with that cycle's result code. The block latches one detection flag and one classification flag per channel. A sticky bit is set either by every completed cycle or, when the mode bit for that event type is high, only by a result that differs from the last one that channel produced.

Software reads the byte through a small command port. One command code reads the byte and leaves it as it is. A second code returns the same byte and empties it at the clock edge that ends the access. A summary interrupt is high while any bit is set. Turning a channel off wipes that channel's two bits.

Channels 1–2 and 3–4 can each be ganged into a 4-pair port. For a ganged port, the flags are held back so that both halves report in the same cycle, as the signature type, discovery mode and pending power-on state require.

Top module: `disc_evt_latch`

## Requirements
- R1: After reset the byte is 0x00 and `irq` is low. Bit n+4 is the classification flag of channel n+1 and bit n is its detection flag (n = 0..3). `chan_off`, `det_done` and `cls_done` use bit n for channel n+1.
- R2: An access with `rd_en` high and `rd_cmd` = 0x04 puts the byte on `rd_data` and changes nothing. An access with any code other than 0x04 or 0x05 returns 0x00 and changes nothing. `rd_data` is 0x00 when `rd_en` is low.
- R3: An access with `rd_cmd` = 0x05 puts the current byte on `rd_data` during the access cycle. After the ending edge all eight bits are 0.
- R4: With `det_chg_mode` = 0, every `det_done` pulse sets the channel's detection flag. With `det_chg_mode` = 1, a pulse sets it only if `det_res` differs from that channel's previous detection result. The stored previous result is 0 after reset and is updated on every pulse.
- R5: Classification flags follow the R4 rule, using `cls_done`, `cls_res` and `cls_chg_mode` with their own stored previous results.
- R6: A `chan_off` pulse clears both flags of that channel and any event the channel holds back. It takes precedence over an event for that channel in the same cycle.
- R7: `irq` is high exactly while the byte is nonzero. It falls in the cycle after a 0x05 access that had no new event in its cycle.
- R8: An event that arrives in the same cycle as a 0x05 access is set after the clear.
- R9: Ganged port (`pair_4p[p]` = 1) without a pending power-on, unless it is a dual-signature port in automatic mode: detection flags of the two channels appear in one cycle, once both channels have finished. Until then, neither flag is set.
- R10: Ganged single-signature port (`sig_dual[p]` = 0): only the channel that reports a classification gets its flag.
- R11: Ganged dual-signature port in semi-automatic mode (`disc_mode` = 01) without a pending power-on: both classification flags appear together once both halves have classified. In manual mode (`disc_mode` = 00) each flag is set on its own.
- R12: Ganged dual-signature port with `pwon_pend[p]` = 1, or in automatic mode (`disc_mode[1]` = 1): each channel sets its detection and classification flags on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_done | input | 4 | Per-channel pulse: detection cycle finished |
| det_res | input | 4*RES_W | Per-channel detection result, channel n at bits [n*RES_W +: RES_W] |
| cls_done | input | 4 | Per-channel pulse: classification cycle finished |
| cls_res | input | 4*CLS_W | Per-channel class result |
| det_chg_mode | input | 1 | 1: detection flags latch only result changes |
| cls_chg_mode | input | 1 | 1: classification flags latch only class changes |
| pair_4p | input | 2 | Bit 0 gangs channels 1–2, bit 1 gangs channels 3–4 |
| sig_dual | input | 2 | Per ganged port: load has two signatures |
| pwon_pend | input | 2 | Per ganged port: power-on command pending |
| disc_mode | input | 2 | 00 manual, 01 semi-automatic, 1x automatic |
| chan_off | input | 4 | Per-channel pulse: channel turned off |
| rd_en | input | 1 | Read access strobe |
| rd_cmd | input | 8 | Command code of the access |
| rd_data | output | 8 | Event byte returned by the access |
| irq | output | 1 | Summary interrupt, high while any flag is set |

## Verification
Two things can land on the same clock edge: a clearing read and a newly completed cycle. The bench drives a 0x05 access in the same cycle as a detection pulse. It then reads the byte back with the side-effect-free command and expects the old bits gone and the new flag still set. A channel-off pulse arriving with that channel's own detection pulse is judged the same way, with the expected result that both flags of the channel read back as 0.

// File: rtl/disc_evt_latch.sv
module disc_evt_latch #(
  parameter int          RES_W    = 4,
  parameter int          CLS_W    = 4,
  parameter logic [7:0]  CMD_PEEK = 8'h04,
  parameter logic [7:0]  CMD_CLR  = 8'h05
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           det_done,
  input  logic [4*RES_W-1:0]   det_res,
  input  logic [3:0]           cls_done,
  input  logic [4*CLS_W-1:0]   cls_res,
  input  logic                 det_chg_mode,
  input  logic                 cls_chg_mode,
  input  logic [1:0]           pair_4p,
  input  logic [1:0]           sig_dual,
  input  logic [1:0]           pwon_pend,
  input  logic [1:0]           disc_mode,
  input  logic [3:0]           chan_off,
  input  logic                 rd_en,
  input  logic [7:0]           rd_cmd,
  output logic [7:0]           rd_data,
  output logic                 irq
);
  localparam int NCH   = 4;
  localparam int NPAIR = NCH / 2;

  logic [7:0]           ev_q, ev_d, set_v, off_m;
  logic [NCH*RES_W-1:0] dprev_q;
  logic [NCH*CLS_W-1:0] cprev_q;
  logic [NCH-1:0]       det_hit, cls_hit;
  logic [NCH-1:0]       dfin_q, dfin_d, dhp_q, dhp_d;
  logic [NCH-1:0]       cfin_q, cfin_d, chp_q, chp_d;
  logic [NPAIR-1:0]     det_joint, cls_joint;

  wire mode_auto = disc_mode[1];
  wire mode_semi = (disc_mode == 2'b01);
  wire rd_clr    = rd_en && (rd_cmd == CMD_CLR);
  wire rd_hit    = rd_en && ((rd_cmd == CMD_PEEK) || (rd_cmd == CMD_CLR));

  assign off_m   = {chan_off, chan_off};
  assign ev_d    = ((rd_clr ? 8'h00 : ev_q) | set_v) & ~off_m;
  assign irq     = |ev_q;
  assign rd_data = rd_hit ? ev_q : 8'h00;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign det_hit[i] = det_done[i] &&
      (!det_chg_mode || (det_res[i*RES_W +: RES_W] != dprev_q[i*RES_W +: RES_W]));
    assign cls_hit[i] = cls_done[i] &&
      (!cls_chg_mode || (cls_res[i*CLS_W +: CLS_W] != cprev_q[i*CLS_W +: CLS_W]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dprev_q[i*RES_W +: RES_W] <= '0;
        cprev_q[i*CLS_W +: CLS_W] <= '0;
      end else begin
        if (det_done[i]) dprev_q[i*RES_W +: RES_W] <= det_res[i*RES_W +: RES_W];
        if (cls_done[i]) cprev_q[i*CLS_W +: CLS_W] <= cls_res[i*CLS_W +: CLS_W];
      end
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int A = 2*p;
    localparam int B = 2*p + 1;

    assign det_joint[p] = pair_4p[p] && !pwon_pend[p] && !(sig_dual[p] && mode_auto);
    assign cls_joint[p] = pair_4p[p] && sig_dual[p] && !pwon_pend[p] && mode_semi;

    wire [1:0] dfin_all = dfin_q[B:A] | det_done[B:A];
    wire [1:0] dacc     = dhp_q[B:A]  | det_hit[B:A];
    wire       dboth    = &dfin_all;
    wire [1:0] cfin_all = cfin_q[B:A] | cls_done[B:A];
    wire [1:0] cacc     = chp_q[B:A]  | cls_hit[B:A];
    wire       cboth    = &cfin_all;

    assign set_v[B:A]     = det_joint[p] ? (dboth ? dacc : 2'b00) : det_hit[B:A];
    assign dfin_d[B:A]    = (det_joint[p] && !dboth) ? (dfin_all & ~chan_off[B:A]) : 2'b00;
    assign dhp_d[B:A]     = (det_joint[p] && !dboth) ? (dacc & ~chan_off[B:A]) : 2'b00;

    assign set_v[B+4:A+4] = cls_joint[p] ? (cboth ? cacc : 2'b00) : cls_hit[B:A];
    assign cfin_d[B:A]    = (cls_joint[p] && !cboth) ? (cfin_all & ~chan_off[B:A]) : 2'b00;
    assign chp_d[B:A]     = (cls_joint[p] && !cboth) ? (cacc & ~chan_off[B:A]) : 2'b00;

    AST_PAIR_DET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (det_joint[p] && !(&(dfin_q[B:A] | det_done[B:A])) && !ev_q[A] && !chan_off[A])
        |=> !ev_q[A]); // R9
    AST_PAIR_CLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_joint[p] && !(&(cfin_q[B:A] | cls_done[B:A])) && !ev_q[A+4] && !chan_off[A])
        |=> !ev_q[A+4]); // R11
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      dfin_q <= '0;
      dhp_q  <= '0;
      cfin_q <= '0;
      chp_q  <= '0;
    end else begin
      ev_q   <= ev_d;
      dfin_q <= dfin_d;
      dhp_q  <= dhp_d;
      cfin_q <= cfin_d;
      chp_q  <= chp_d;
    end
  end

  AST_PEEK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_cmd != CMD_CLR && set_v == 8'h00 && chan_off == 4'h0) |=> $stable(ev_q)); // R2
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_v == 8'h00) |=> (ev_q == 8'h00)); // R3
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_v == 8'h00) |=> !irq); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_off != 4'h0) |=> ((ev_q & {$past(chan_off), $past(chan_off)}) == 8'h00)); // R6
  AST_CLR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set_v & ~off_m) != 8'h00)
      |=> ((ev_q & $past(set_v & ~off_m)) == $past(set_v & ~off_m))); // R8
endmodule

// File: tb/tb_disc_evt_latch.sv
`timescale 1ns/1ps
module tb_disc_evt_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  det_done = '0, cls_done = '0, chan_off = '0;
  logic [15:0] det_res = '0, cls_res = '0;
  logic        det_chg_mode = 1'b0, cls_chg_mode = 1'b0;
  logic [1:0]  pair_4p = '0, sig_dual = '0, pwon_pend = '0, disc_mode = 2'b01;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_cmd = '0;
  logic [7:0]  rd_data;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [7:0]  v;

  always #4 clk = ~clk;

  disc_evt_latch dut (
    .clk(clk), .rst_n(rst_n), .det_done(det_done), .det_res(det_res),
    .cls_done(cls_done), .cls_res(cls_res), .det_chg_mode(det_chg_mode),
    .cls_chg_mode(cls_chg_mode), .pair_4p(pair_4p), .sig_dual(sig_dual),
    .pwon_pend(pwon_pend), .disc_mode(disc_mode), .chan_off(chan_off),
    .rd_en(rd_en), .rd_cmd(rd_cmd), .rd_data(rd_data), .irq(irq));

  // {det_done, cls_done, det_chg, cls_chg, det_res, cls_res, clear, expected byte}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 1'b0, 1'b0, 4'd3, 4'd0, 1'b0, 8'h01},  // R4 any cycle
    {4'b0010, 4'b0100, 1'b0, 1'b0, 4'd3, 4'd2, 1'b0, 8'h43},  // R5 any cycle
    {4'b0000, 4'b0000, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 8'h00},  // R3
    {4'b0001, 4'b0000, 1'b1, 1'b0, 4'd3, 4'd0, 1'b0, 8'h00},  // R4 same result
    {4'b0001, 4'b0000, 1'b1, 1'b0, 4'd5, 4'd0, 1'b0, 8'h01},  // R4 changed
    {4'b1100, 4'b0000, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 8'h01},  // R4 equals reset value
    {4'b0000, 4'b0100, 1'b0, 1'b1, 4'd0, 4'd2, 1'b0, 8'h01},  // R5 same class
    {4'b0000, 4'b1100, 1'b0, 1'b1, 4'd0, 4'd2, 1'b0, 8'h81},  // R5 changed on ch4
    {4'b0010, 4'b0000, 1'b0, 1'b0, 4'd1, 4'd0, 1'b1, 8'h02},  // R8 survives clear
    {4'b0000, 4'b1111, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 8'hF2}   // R1 layout
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] dd, input logic [3:0] cd, input logic [3:0] dr,
                       input logic [3:0] cr, input logic clr, input logic [3:0] off);
    @(negedge clk);
    det_done = dd; cls_done = cd; det_res = {4{dr}}; cls_res = {4{cr}};
    chan_off = off; rd_en = clr; rd_cmd = clr ? 8'h05 : 8'h00;
    @(posedge clk); #1;
    det_done = '0; cls_done = '0; chan_off = '0; rd_en = 1'b0; rd_cmd = '0;
  endtask

  task automatic peek(output logic [7:0] val);
    rd_en = 1'b1; rd_cmd = 8'h04;
    #1 val = rd_data;
    rd_en = 1'b0; rd_cmd = 8'h00;
  endtask

  task automatic clear_all();
    apply(4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 peek(v);
    check("R1 reset byte", v, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      det_chg_mode = VEC[i][18];
      cls_chg_mode = VEC[i][17];
      apply(VEC[i][26:23], VEC[i][22:19], VEC[i][16:13], VEC[i][12:9], VEC[i][8], 4'h0);
      peek(v);
      check($sformatf("R4/R5/R8 vector %0d", i), v, VEC[i][7:0]);
    end
    det_chg_mode = 1'b0; cls_chg_mode = 1'b0;

    check("R7 irq while set", {7'b0, irq}, 8'h01);
    @(negedge clk); rd_en = 1'b1; rd_cmd = 8'h05;
    #1 check("R3 clearing read data", rd_data, 8'hF2);
    @(posedge clk); #1 rd_en = 1'b0; rd_cmd = 8'h00;
    check("R7 irq released", {7'b0, irq}, 8'h00);
    peek(v);
    check("R3 byte after clear", v, 8'h00);

    apply(4'b0001, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R2 first peek", v, 8'h01);
    peek(v); check("R2 repeated peek", v, 8'h01);
    @(negedge clk); rd_en = 1'b1; rd_cmd = 8'h06;
    #1 check("R2 unknown command data", rd_data, 8'h00);
    @(posedge clk); #1 rd_en = 1'b0; rd_cmd = 8'h00;
    peek(v); check("R2 unknown command no effect", v, 8'h01);

    apply(4'b0010, 4'b0010, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R6 setup", v, 8'h23);
    apply(4'b0010, 4'h0, 4'h0, 4'h0, 1'b0, 4'b0010);
    peek(v); check("R6 off beats event", v, 8'h01);
    clear_all();

    pair_4p = 2'b01; sig_dual = 2'b00; pwon_pend = 2'b00; disc_mode = 2'b01;
    apply(4'b0001, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R9 first half held", v, 8'h00);
    apply(4'b0010, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R9 both together", v, 8'h03);
    apply(4'h0, 4'b0001, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R10 single signature class", v, 8'h13);
    clear_all();

    sig_dual = 2'b01;
    apply(4'h0, 4'b0010, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R11 semi-auto held", v, 8'h00);
    apply(4'h0, 4'b0001, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R11 semi-auto together", v, 8'h30);
    clear_all();
    disc_mode = 2'b00;
    apply(4'h0, 4'b0001, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R11 manual independent", v, 8'h10);
    clear_all();

    disc_mode = 2'b01; pwon_pend = 2'b01;
    apply(4'b0001, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R12 pending det independent", v, 8'h01);
    apply(4'h0, 4'b0010, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R12 pending cls independent", v, 8'h21);
    clear_all();
    pwon_pend = 2'b00; disc_mode = 2'b10;
    apply(4'b0010, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0);
    peek(v); check("R12 auto det independent", v, 8'h02);
    clear_all();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule